// File: doc/BRIEF.md
# Interlocked Parallel Handshake Port

This block moves bytes between two devices over an 8-bit parallel bus, paced by a two-wire interlocked handshake. One control bit picks the direction. As a transmitter, the block drives the data bus and a strobe, and it waits for the far side's acknowledge. As a receiver, it captures the bus when the far side strobes and answers with an acknowledge. Both handshake wires are active low. The same two pads carry both roles: the output pad and the input pad swap meaning with the direction bit.

Software carries every byte. In transmit mode it writes the data register when the interrupt reports an empty output latch. In receive mode it reads the data register when the interrupt reports a full input latch. A small setup register holds the delay between loading a byte and asserting the strobe. While the port is disabled, the output pad follows the general-purpose direction and level inputs. While it is enabled, the handshake logic owns the pad.

Top module: `hsk_par_port`

## Requirements
- R1: Control register (address 2) bit 0 enables the port and bit 1 selects transmit (1) or receive (0). In transmit mode `hs_out` is the strobe, `hs_in` is the acknowledge, and `pd_oe` is 1. In receive mode `hs_out` is the acknowledge, `hs_in` is the strobe, and `pd_oe` is 0. Both handshake signals are active low and idle high.
- R2: In transmit mode, if the acknowledge has been high for a while, the strobe falls exactly N+2 clock edges after the edge that accepts a data-register write (address 0). N is the 4-bit setup register (address 1), so N=0 gives the shortest delay.
- R3: While the strobe is low, a low acknowledge marks the byte as sent. The strobe returns high, the output latch becomes empty, and the interrupt rises. `pd_out` carries the loaded byte for the whole strobe.
- R4: After a transfer, the strobe stays high until a new byte has been loaded and the acknowledge has returned high. Only then does the setup interval begin again.
- R5: A data-register write while the output latch still holds an unsent byte is ignored. The pending byte is not altered and no extra byte is sent.
- R6: In receive mode, a low strobe with an empty input latch captures `pd_in` into the latch, pulls the acknowledge low, and raises the interrupt.
- R7: The acknowledge stays low until the host reads the data register. It goes high on the edge that accepts that read. A strobe still held low after the read is not captured again.
- R8: While enabled, `hs_oe` is 1 and `gp_dir`/`gp_dat` have no effect on `hs_out`. While disabled, `hs_out` equals `gp_dat` and `hs_oe` equals `gp_dir`.
- R9: The interrupt is high when the port is enabled and either the output latch is empty (transmit) or the input latch is full (receive). Writing the data register in transmit mode, or reading it in receive mode, clears it. It is low while the port is disabled.
- R10: After reset, the setup and control registers read 0. Written values read back from addresses 1 and 2. Address 3 returns the latch flag in bit 0 (transmit empty / receive full) and the handshake output level in bit 1.
- R11: `hs_in` passes through a two-flop synchronizer. A level change driven before edge k takes effect on `hs_out` after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host register write strobe |
| bus_rd | input | 1 | Host register read strobe |
| bus_addr | input | 2 | Register select: 0 data, 1 setup, 2 control, 3 status |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data |
| irq | output | 1 | Interrupt request |
| pd_in | input | 8 | Parallel data bus, inbound |
| pd_out | output | 8 | Parallel data bus, outbound |
| pd_oe | output | 1 | Parallel data bus drive enable |
| hs_in | input | 1 | Handshake input pad (acknowledge or strobe) |
| hs_out | output | 1 | Handshake output pad (strobe or acknowledge) |
| hs_oe | output | 1 | Handshake output pad drive enable |
| gp_dir | input | 1 | General-purpose direction for the output pad |
| gp_dat | input | 1 | General-purpose level for the output pad |

## Verification
A wrong transmit state shows up on `hs_out` within a few cycles. The strobe falls at the wrong edge after a write, it fails to rise three edges after the acknowledge drops, or it re-asserts while the acknowledge is still low. A corrupted output latch appears on `pd_out` at the moment the far side samples it during the strobe. In receive mode, a bad state shows up as an acknowledge that rises before the host read, or that falls again from a strobe already served. A bad input latch shows up as a byte read back that differs from the byte driven while the strobe was low.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    localparam int DATA_W  = 8;
    localparam int SETUP_W = 4;
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA  = 2'd0,
        REG_SETUP = 2'd1,
        REG_CTRL  = 2'd2,
        REG_STAT  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_SETUP  = 2'd1,
        TX_STROBE = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_WAIT  = 2'd0,
        RX_HOLD  = 2'd1,
        RX_DRAIN = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic tx_mode;
        logic enable;
    } ctrl_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a);
    endfunction

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
    parameter int                 WIDTH   = 1,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hsk_tx_engine.sv
module hsk_tx_engine
    import hsk_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = SETUP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic [SW-1:0] setup_val,
    input  logic          ack_n_s,
    output logic          stb_n,
    output logic          empty,
    output logic [DW-1:0] data
);
    tx_state_e     state;
    logic [SW-1:0] cnt;
    logic          full;
    logic [DW-1:0] latch;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state <= TX_IDLE;
            cnt   <= '0;
            full  <= 1'b0;
            if (rst) latch <= '0;
        end else begin
            if (load && !full) begin
                full  <= 1'b1;
                latch <= load_data;
            end
            unique case (state)
                TX_IDLE: begin
                    if (full && ack_n_s) begin
                        state <= TX_SETUP;
                        cnt   <= setup_val;
                    end
                end
                TX_SETUP: begin
                    if (cnt == '0) state <= TX_STROBE;
                    else           cnt   <= cnt - 1'b1;
                end
                TX_STROBE: begin
                    if (!ack_n_s) begin
                        state <= TX_IDLE;
                        full  <= 1'b0;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign stb_n = (state != TX_STROBE);
    assign empty = !full;
    assign data  = latch;

    // R3: strobe only with a loaded byte behind it
    a_r3_strobe_has_data: assert property (@(posedge clk) disable iff (rst)
        !stb_n |-> full);

    // R3: acknowledge during strobe ends the transfer on the next edge
    a_r3_done_empties: assert property (@(posedge clk) disable iff (rst || clr)
        (!stb_n && !ack_n_s) |=> (stb_n && !full));

    // R4: no new strobe while the acknowledge is still low
    a_r4_hold_while_ack_low: assert property (@(posedge clk) disable iff (rst || clr)
        (stb_n && !ack_n_s) |=> stb_n);

    // R5: a write into an occupied latch leaves it untouched
    a_r5_latch_stable: assert property (@(posedge clk) disable iff (rst || clr)
        (full && load) |=> $stable(data));
endmodule

// File: rtl/hsk_rx_engine.sv
module hsk_rx_engine
    import hsk_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          pop,
    input  logic          stb_n_s,
    input  logic [DW-1:0] pin_data,
    output logic          ack_n,
    output logic          full,
    output logic [DW-1:0] data
);
    rx_state_e     state;
    logic [DW-1:0] latch;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state <= RX_WAIT;
            if (rst) latch <= '0;
        end else begin
            unique case (state)
                RX_WAIT: begin
                    if (!stb_n_s) begin
                        latch <= pin_data;
                        state <= RX_HOLD;
                    end
                end
                RX_HOLD:  if (pop)     state <= RX_DRAIN;
                RX_DRAIN: if (stb_n_s) state <= RX_WAIT;
                default:  state <= RX_WAIT;
            endcase
        end
    end

    assign ack_n = (state != RX_HOLD);
    assign full  = (state == RX_HOLD);
    assign data  = latch;

    // R6: a strobe seen in the wait state captures the bus and acknowledges
    a_r6_capture: assert property (@(posedge clk) disable iff (rst || clr)
        (state == RX_WAIT && !stb_n_s) |=> (!ack_n && data == $past(pin_data)));

    // R7: acknowledge held until the host reads
    a_r7_ack_held: assert property (@(posedge clk) disable iff (rst || clr)
        (!ack_n && !pop) |=> !ack_n);

    // R7: a strobe already served is not captured again
    a_r7_no_recapture: assert property (@(posedge clk) disable iff (rst || clr)
        (state == RX_DRAIN && !stb_n_s) |=> ack_n);
endmodule

// File: rtl/hsk_par_port.sv
module hsk_par_port
    import hsk_pkg::*;
#(
    parameter int DW          = DATA_W,
    parameter int SW          = SETUP_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    input  logic [DW-1:0] pd_in,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    input  logic          hs_in,
    output logic          hs_out,
    output logic          hs_oe,
    input  logic          gp_dir,
    input  logic          gp_dat
);
    localparam int CW = $bits(ctrl_t);

    ctrl_t         ctrl_q;
    logic [SW-1:0] setup_q;
    reg_sel_e      sel;
    logic          tx_active, rx_active;
    logic          hs_in_s;
    logic          tx_stb_n, tx_empty, rx_ack_n, rx_full;
    logic [DW-1:0] tx_data, rx_data;
    logic          hs_int, ready;

    assign sel       = decode_addr(bus_addr);
    assign tx_active = ctrl_q.enable &&  ctrl_q.tx_mode;
    assign rx_active = ctrl_q.enable && !ctrl_q.tx_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            setup_q <= '0;
        end else if (bus_wr) begin
            if (sel == REG_SETUP) setup_q <= bus_wdata[SW-1:0];
            if (sel == REG_CTRL)  ctrl_q  <= ctrl_t'(bus_wdata[CW-1:0]);
        end
    end

    hsk_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (hs_in),
        .q   (hs_in_s)
    );

    hsk_tx_engine #(.DW(DW), .SW(SW)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .clr       (!tx_active),
        .load      (bus_wr && sel == REG_DATA && tx_active),
        .load_data (bus_wdata),
        .setup_val (setup_q),
        .ack_n_s   (hs_in_s),
        .stb_n     (tx_stb_n),
        .empty     (tx_empty),
        .data      (tx_data)
    );

    hsk_rx_engine #(.DW(DW)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .clr      (!rx_active),
        .pop      (bus_rd && sel == REG_DATA && rx_active),
        .stb_n_s  (hs_in_s),
        .pin_data (pd_in),
        .ack_n    (rx_ack_n),
        .full     (rx_full),
        .data     (rx_data)
    );

    always_comb begin
        if (tx_active)      hs_int = tx_stb_n;
        else if (rx_active) hs_int = rx_ack_n;
        else                hs_int = 1'b1;
    end

    assign ready  = tx_active ? tx_empty : rx_full;
    assign irq    = (tx_active && tx_empty) || (rx_active && rx_full);
    assign hs_out = ctrl_q.enable ? hs_int : gp_dat;
    assign hs_oe  = ctrl_q.enable ? 1'b1   : gp_dir;
    assign pd_out = tx_data;
    assign pd_oe  = tx_active;

    always_comb begin
        unique case (sel)
            REG_DATA:  bus_rdata = ctrl_q.tx_mode ? tx_data : rx_data;
            REG_SETUP: bus_rdata = DW'(setup_q);
            REG_CTRL:  bus_rdata = DW'(ctrl_q);
            REG_STAT:  bus_rdata = DW'({hs_int, ready});
            default:   bus_rdata = '0;
        endcase
    end

    // R1: transmit mode drives the data bus
    a_r1_tx_bus_driven: assert property (@(posedge clk) disable iff (rst)
        tx_active |-> pd_oe);

    // R9: host read of a full receive latch clears the interrupt
    a_r9_irq_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && sel == REG_DATA && rx_active && irq) |=> !irq);

    // R9: host write of the empty transmit latch clears the interrupt
    a_r9_irq_clear_on_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == REG_DATA && tx_active && irq) |=> !irq);
endmodule

// File: tb/hsk_par_port_bench.sv
module hsk_par_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       irq;
    logic [7:0] pd_in = '0, pd_out;
    logic       pd_oe, hs_in = 1'b1, hs_out, hs_oe;
    logic       gp_dir = 1'b0, gp_dat = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit auto_ack = 1'b0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #10 clk = ~clk;

    hsk_par_port u_hsk_par_port (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
        .hs_in(hs_in), .hs_out(hs_out), .hs_oe(hs_oe),
        .gp_dir(gp_dir), .gp_dat(gp_dat)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #5 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // count edges until hs_out reaches the given level
    task automatic edges_until(input logic lvl, output int n);
        n = 0;
        while (hs_out !== lvl && n < 60) begin
            @(posedge clk); @(negedge clk); n++;
        end
    endtask

    // remote receiver: compares each strobed byte with the scoreboard
    always begin
        @(negedge clk);
        if (auto_ack && pd_oe && hs_out == 1'b0) begin
            if (tx_q.size() == 0) begin
                check(1'b0, "R3 unexpected strobe", pd_out, 0);
            end else begin
                logic [7:0] e;
                e = tx_q.pop_front();
                check(pd_out == e, "R3 strobed byte", pd_out, e);
            end
            cycles(2);
            hs_in = 1'b0;
            while (hs_out == 1'b0) @(negedge clk);
            cycles(2);
            hs_in = 1'b1;
        end
    end

    task automatic tx_byte(input logic [7:0] d, input int nset);
        int n;
        while (hs_in !== 1'b1) @(negedge clk);
        cycles(4);
        check(irq == 1'b1, "R9 irq on empty latch", irq, 1);
        tx_q.push_back(d);
        host_write(2'd0, d);
        edges_until(1'b0, n);
        check(n == nset + 2, "R2 setup delay", n, nset + 2);
        while (tx_q.size() != 0 || hs_out == 1'b0 || hs_in == 1'b0) @(negedge clk);
    endtask

    task automatic rx_send(input logic [7:0] d);
        int n;
        rx_q.push_back(d);
        @(negedge clk);
        pd_in = d; hs_in = 1'b0;
        edges_until(1'b0, n);
        check(n == 3, "R6 R11 ack after strobe", n, 3);
        check(irq == 1'b1, "R6 irq on capture", irq, 1);
    endtask

    task automatic rx_collect();
        logic [7:0] got, e;
        host_read(2'd0, got);
        e = (rx_q.size() != 0) ? rx_q.pop_front() : 8'hxx;
        check(got == e, "R6 captured byte", got, e);
        check(hs_out == 1'b1, "R7 ack high after read", hs_out, 1);
        check(irq == 1'b0, "R9 irq cleared by read", irq, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        int n;
        cycles(3);
        rst = 1'b0;
        cycles(1);

        // reset state
        check(irq == 1'b0, "R9 irq low after reset", irq, 0);
        check(hs_oe == gp_dir && hs_out == gp_dat, "R8 pad follows gp when disabled", hs_out, gp_dat);
        host_read(2'd1, r); check(r == 8'h00, "R10 setup reset", r, 0);
        host_read(2'd2, r); check(r == 8'h00, "R10 ctrl reset", r, 0);

        // transmit mode, setup 3
        host_write(2'd1, 8'h03);
        host_write(2'd2, 8'h03);
        host_read(2'd1, r); check(r == 8'h03, "R10 setup readback", r, 3);
        host_read(2'd2, r); check(r == 8'h03, "R10 ctrl readback", r, 3);
        host_read(2'd3, r); check(r == 8'h03, "R10 status tx empty, strobe high", r, 3);
        check(irq == 1'b1, "R9 irq on empty tx latch", irq, 1);
        check(pd_oe == 1'b1 && hs_out == 1'b1, "R1 tx pins idle", {pd_oe, hs_out}, 3);
        gp_dir = 1'b1; gp_dat = 1'b0;
        cycles(1);
        check(hs_out == 1'b1 && hs_oe == 1'b1, "R8 gp ignored when enabled", hs_out, 1);

        host_write(2'd0, 8'hA5);
        check(irq == 1'b0, "R9 irq cleared by write", irq, 0);
        edges_until(1'b0, n);
        check(n == 5, "R2 strobe after setup 3", n, 5);
        check(pd_out == 8'hA5, "R3 bus carries byte", pd_out, 8'hA5);
        host_write(2'd0, 8'h11);
        check(pd_out == 8'hA5, "R5 write while full ignored", pd_out, 8'hA5);
        check(hs_out == 1'b0, "R3 strobe held until ack", hs_out, 0);
        hs_in = 1'b0;
        edges_until(1'b1, n);
        check(n == 3, "R3 R11 strobe release after ack", n, 3);
        check(irq == 1'b1, "R3 irq after transfer", irq, 1);
        host_write(2'd0, 8'h3C);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(hs_out == 1'b1, "R4 no strobe while ack low", hs_out, 1);
        end
        @(negedge clk);
        hs_in = 1'b1;
        edges_until(1'b0, n);
        check(n == 7, "R4 strobe after ack release", n, 7);
        check(pd_out == 8'h3C, "R5 next byte is the newly loaded one", pd_out, 8'h3C);
        hs_in = 1'b0;
        while (hs_out == 1'b0) @(negedge clk);
        hs_in = 1'b1;
        cycles(4);

        // scoreboard-driven transfers
        auto_ack = 1'b1;
        host_write(2'd1, 8'h00);
        tx_byte(8'h5E, 0);
        tx_byte(8'h81, 0);
        host_write(2'd1, 8'h0F);
        tx_byte(8'hFF, 15);
        host_write(2'd1, 8'h02);
        tx_byte(8'h00, 2);
        tx_byte(8'h6B, 2);
        auto_ack = 1'b0;
        check(tx_q.size() == 0, "R3 all bytes strobed", tx_q.size(), 0);

        // receive mode
        host_write(2'd2, 8'h01);
        cycles(1);
        check(pd_oe == 1'b0 && hs_out == 1'b1, "R1 rx pins idle", {pd_oe, hs_out}, 1);
        check(irq == 1'b0, "R9 irq low with empty rx latch", irq, 0);
        rx_send(8'h5A);
        pd_in = 8'h00;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(hs_out == 1'b0, "R7 ack held before read", hs_out, 0);
        end
        hs_in = 1'b1;
        cycles(4);
        check(hs_out == 1'b0, "R7 ack held after strobe release", hs_out, 0);
        host_read(2'd3, r); check(r == 8'h01, "R10 status rx full, ack low", r, 1);
        rx_collect();

        rx_send(8'hC3);
        rx_collect();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(hs_out == 1'b1, "R7 no recapture of held strobe", hs_out, 1);
        end
        hs_in = 1'b1;
        cycles(4);
        rx_send(8'h7E);
        hs_in = 1'b1;
        rx_collect();

        // disable: pad returns to general-purpose control
        host_write(2'd2, 8'h00);
        gp_dir = 1'b1; gp_dat = 1'b0;
        cycles(1);
        check(hs_out == 1'b0 && hs_oe == 1'b1, "R8 gp drives pad when disabled", hs_out, 0);
        gp_dir = 1'b0; gp_dat = 1'b1;
        cycles(1);
        check(hs_out == 1'b1 && hs_oe == 1'b0, "R8 gp level and direction", hs_oe, 0);
        check(irq == 1'b0, "R9 irq low when disabled", irq, 0);

        finish_run();
    end
endmodule